// File: doc/BRIEF.md
# Framed Binary Write Parser

This block sits behind a serial byte receiver. Each received byte arrives with a one-cycle valid strobe. The block turns a framed binary write command into a series of register-file write cycles. A frame opens with a marker byte and a command byte. A big-endian start address follows, then a count byte, then the payload. Each payload byte becomes exactly one single-cycle write, and the address steps up by one after every byte.

Bit 0 of the command byte asks for a confirmation. When that bit is set, the block presents a fixed acknowledge code on a byte output with its own valid pulse once the whole frame has been written. If the transmitter that takes this byte reports busy, the block holds the acknowledge until the transmitter is free. A command byte that is not recognised throws the frame away. Bytes that arrive between frames and are not the marker are ignored.

Top module: `frame_write_parser`

## Requirements
- R1: While idle, only a byte equal to 0x00 starts a frame. Any other byte leaves the parser idle and produces no write.
- R2: The byte after the marker is the command. If bits 7..1 equal 0b0010000 (0x20 or 0x21), the frame is a write and bit 0 requests an acknowledge. Any other value discards the frame and returns to idle.
- R3: The two bytes after the command form the 16-bit start address, most significant byte first.
- R4: The byte after the address is the payload count. A count of 0 means 256 payload bytes.
- R5: Each payload byte strobe gives exactly one `bus_we` pulse, one clock long, in the cycle after the strobe's clock edge. `bus_addr` and `bus_wdata` carry that byte's address and value in the same cycle.
- R6: Payload byte k is written to start address + k, modulo 2^16, so 0xFFFF is followed by 0x0000.
- R7: After the last payload byte the parser is idle again, and it needs a new 0x00 marker before it writes again.
- R8: When acknowledge was requested, `ack_vld` pulses for one cycle with `ack_byte` = 0xA5 in the cycle after the final write pulse if `ack_busy` is low. While `ack_busy` is high the pulse is held back, and it fires in the cycle after the edge that sees `ack_busy` low.
- R9: The parser advances only on cycles with `rx_vld` high. Idle cycles between bytes of a frame change nothing.
- R10: An asynchronous active-low `rst_n` returns the parser to idle, drives `bus_we`, `bus_addr`, `bus_wdata`, `ack_vld` and `ack_byte` to zero, and drops any pending acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_vld | input | 1 | One-cycle strobe marking a received byte |
| rx_byte | input | 8 | Received byte, valid with `rx_vld` |
| ack_busy | input | 1 | Transmitter cannot take an acknowledge byte now |
| bus_addr | output | 16 | Write address |
| bus_wdata | output | 8 | Write data |
| bus_we | output | 1 | One-cycle write strobe |
| ack_vld | output | 1 | One-cycle strobe for `ack_byte` |
| ack_byte | output | 8 | Acknowledge code |

## Verification
The bench builds the block with its default parameters: a 16-bit address, 8-bit data and an 8-bit count. With these values a full 256-byte burst (count byte 0) and the address wrap from 0xFFFF to 0x0000 each take only a few hundred cycles, so both are driven directly. The vector table interleaves idle cycles with frame bytes and includes a rejected command. Directed cases then hold the transmitter busy and apply reset in the middle of a frame while an acknowledge is still pending.

// File: rtl/fwp_pkg.sv
package fwp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_CMD  = 3'd1,
    ST_ADDR = 3'd2,
    ST_LEN  = 3'd3,
    ST_DATA = 3'd4
  } fwp_state_e;

  localparam logic [7:0] MARK_DEF   = 8'h00;
  localparam logic [7:0] CMD_WR_DEF = 8'h20;
  localparam logic [7:0] ACK_DEF    = 8'hA5;

endpackage

// File: rtl/fwp_seq.sv
module fwp_seq
  import fwp_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter logic [DATA_W-1:0] MARK   = MARK_DEF,
  parameter logic [DATA_W-1:0] CMD_WR = CMD_WR_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_vld,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              last_beat,
  output logic              addr_ld,
  output logic              len_ld,
  output logic              beat,
  output logic              ack_trig
);

  localparam int unsigned ADDR_BYTES = ADDR_W / DATA_W;
  localparam int unsigned IDX_W      = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ADDR_BYTES - 1);

  fwp_state_e       st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             ackreq_q, ackreq_d;

  always_comb begin
    st_d     = st_q;
    idx_d    = idx_q;
    ackreq_d = ackreq_q;
    if (rx_vld) begin
      unique case (st_q)
        ST_IDLE: begin
          if (rx_byte == MARK) st_d = ST_CMD;
        end
        ST_CMD: begin
          if (rx_byte[DATA_W-1:1] == CMD_WR[DATA_W-1:1]) begin
            st_d     = ST_ADDR;
            ackreq_d = rx_byte[0];
            idx_d    = '0;
          end else begin
            st_d = ST_IDLE;
          end
        end
        ST_ADDR: begin
          if (idx_q == IDX_LAST) st_d = ST_LEN;
          else                   idx_d = idx_q + 1'b1;
        end
        ST_LEN: st_d = ST_DATA;
        ST_DATA: begin
          if (last_beat) st_d = ST_IDLE;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      idx_q    <= '0;
      ackreq_q <= 1'b0;
    end else if (rx_vld) begin
      st_q     <= st_d;
      idx_q    <= idx_d;
      ackreq_q <= ackreq_d;
    end
  end

  assign addr_ld  = rx_vld && (st_q == ST_ADDR);
  assign len_ld   = rx_vld && (st_q == ST_LEN);
  assign beat     = rx_vld && (st_q == ST_DATA);
  assign ack_trig = beat && last_beat && ackreq_q;

endmodule

// File: rtl/fwp_burst.sv
module fwp_burst #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              addr_ld,
  input  logic              len_ld,
  input  logic              beat,
  output logic              last_beat,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_we
);

  localparam int unsigned CNT_W = DATA_W + 1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(1) << DATA_W;
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  rem_q, rem_d;
  logic [ADDR_W-1:0] baddr_q;
  logic [DATA_W-1:0] bdata_q;
  logic              we_q;

  always_comb begin
    addr_d = addr_q;
    rem_d  = rem_q;
    if (addr_ld) begin
      addr_d = (addr_q << DATA_W) | ADDR_W'(rx_byte);
    end
    if (len_ld) begin
      rem_d = (rx_byte == '0) ? CNT_FULL : {1'b0, rx_byte};
    end
    if (beat) begin
      addr_d = addr_q + 1'b1;
      rem_d  = rem_q - 1'b1;
    end
  end

  assign last_beat = (rem_q == CNT_ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rem_q  <= '0;
    end else if (addr_ld || len_ld || beat) begin
      addr_q <= addr_d;
      rem_q  <= rem_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q <= 1'b0;
    end else begin
      we_q <= beat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      baddr_q <= '0;
      bdata_q <= '0;
    end else if (beat) begin
      baddr_q <= addr_q;
      bdata_q <= rx_byte;
    end
  end

  assign bus_addr  = baddr_q;
  assign bus_wdata = bdata_q;
  assign bus_we    = we_q;

endmodule

// File: rtl/fwp_ack.sv
module fwp_ack #(
  parameter int unsigned DATA_W = 8,
  parameter logic [DATA_W-1:0] ACK_CODE = 8'hA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack_trig,
  input  logic              ack_busy,
  output logic              ack_vld,
  output logic [DATA_W-1:0] ack_byte
);

  logic              pend_q, pend_d;
  logic              vld_q;
  logic [DATA_W-1:0] byte_q;
  logic              fire;

  assign fire = pend_q && !ack_busy;

  always_comb begin
    if (fire) pend_d = ack_trig;
    else      pend_d = pend_q || ack_trig;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      vld_q  <= fire;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
    end else if (fire) begin
      byte_q <= ACK_CODE;
    end
  end

  assign ack_vld  = vld_q;
  assign ack_byte = byte_q;

endmodule

// File: rtl/frame_write_parser.sv
module frame_write_parser
  import fwp_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter logic [DATA_W-1:0] MARK     = MARK_DEF,
  parameter logic [DATA_W-1:0] CMD_WR   = CMD_WR_DEF,
  parameter logic [DATA_W-1:0] ACK_CODE = ACK_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_vld,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              ack_busy,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_we,
  output logic              ack_vld,
  output logic [DATA_W-1:0] ack_byte
);

  logic addr_ld, len_ld, beat, ack_trig, last_beat;

  fwp_seq #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .MARK   (MARK),
    .CMD_WR (CMD_WR)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_vld    (rx_vld),
    .rx_byte   (rx_byte),
    .last_beat (last_beat),
    .addr_ld   (addr_ld),
    .len_ld    (len_ld),
    .beat      (beat),
    .ack_trig  (ack_trig)
  );

  fwp_burst #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_burst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_byte   (rx_byte),
    .addr_ld   (addr_ld),
    .len_ld    (len_ld),
    .beat      (beat),
    .last_beat (last_beat),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we)
  );

  fwp_ack #(
    .DATA_W   (DATA_W),
    .ACK_CODE (ACK_CODE)
  ) u_ack (
    .clk      (clk),
    .rst_n    (rst_n),
    .ack_trig (ack_trig),
    .ack_busy (ack_busy),
    .ack_vld  (ack_vld),
    .ack_byte (ack_byte)
  );

endmodule

// File: rtl/fwp_checker.sv
module fwp_checker #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter logic [DATA_W-1:0] ACK_CODE = 8'hA5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_vld,
  input logic [DATA_W-1:0] rx_byte,
  input logic              ack_busy,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_we,
  input logic              ack_vld,
  input logic [DATA_W-1:0] ack_byte
);

  // R5 / R9: a write only follows a byte strobe, carrying that byte
  a_r5_we_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |-> $past(rx_vld));

  a_r5_data_is_byte: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |-> bus_wdata == $past(rx_byte));

  // R6: back-to-back writes step the address by one, with wrap
  a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && $past(bus_we)) |-> bus_addr == ADDR_W'($past(bus_addr) + 1'b1));

  // R8: acknowledge is a single-cycle pulse with the fixed code
  a_r8_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vld |=> !ack_vld);

  a_r8_ack_code: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vld |-> ack_byte == ACK_CODE);

  a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ack_busy |=> !ack_vld);

endmodule

bind frame_write_parser fwp_checker #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .ACK_CODE (ACK_CODE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_vld    (rx_vld),
  .rx_byte   (rx_byte),
  .ack_busy  (ack_busy),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_we    (bus_we),
  .ack_vld   (ack_vld),
  .ack_byte  (ack_byte)
);

// File: tb/frame_write_parser_tb_top.sv
`timescale 1ns/1ps
module frame_write_parser_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_vld;
  logic [7:0]  rx_byte;
  logic        ack_busy;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_we;
  logic        ack_vld;
  logic [7:0]  ack_byte;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  frame_write_parser dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_vld    (rx_vld),
    .rx_byte   (rx_byte),
    .ack_busy  (ack_busy),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .ack_vld   (ack_vld),
    .ack_byte  (ack_byte)
  );

  // entry: {vld, byte, exp_we, exp_addr[15:0], exp_data[7:0], exp_ack}
  localparam int NV = 37;
  localparam logic [34:0] VEC [0:NV-1] = '{
    // R1: stray byte while idle
    {1'b1, 8'h33, 1'b0, 16'h0000, 8'h00, 1'b0},
    // frame with acknowledge, R3 big-endian address
    {1'b1, 8'h00, 1'b0, 16'h0000, 8'h00, 1'b0},
    {1'b1, 8'h21, 1'b0, 16'h0000, 8'h00, 1'b0},
    {1'b1, 8'h12, 1'b0, 16'h0000, 8'h00, 1'b0},
    {1'b1, 8'h34, 1'b0, 16'h0000, 8'h00, 1'b0},
    {1'b1, 8'h03, 1'b0, 16'h0000, 8'h00, 1'b0},
    {1'b1, 8'hAA, 1'b1, 16'h1234, 8'hAA, 1'b0},
    {1'b1, 8'hBB, 1'b1, 16'h1235, 8'hBB, 1'b0},
    {1'b1, 8'hCC, 1'b1, 16'h1236, 8'hCC, 1'b0},
    {1'b0, 8'h00, 1'b0, 16'h0000, 8'h00, 1'b1},
    {1'b0, 8'h00, 1'b0, 16'h0000, 8'h00, 1'b0},
    // R9: frame without acknowledge, gaps between bytes
    {1'b1, 8'h00, 1'b0, 16'h0000, 8'h00, 1'b0},
    {1'b0, 8'h55, 1'b0, 16'h0000, 8'h00, 1'b0},
    {1'b1, 8'h20, 1'b0, 16'h0000, 8'h00, 1'b0},
    {1'b1, 8'h00, 1'b0, 16'h0000, 8'h00, 1'b0},
    {1'b0, 8'h00, 1'b0, 16'h0000, 8'h00, 1'b0},
    {1'b1, 8'h05, 1'b0, 16'h0000, 8'h00, 1'b0},
    {1'b1, 8'h02, 1'b0, 16'h0000, 8'h00, 1'b0},
    {1'b1, 8'h11, 1'b1, 16'h0005, 8'h11, 1'b0},
    {1'b0, 8'h99, 1'b0, 16'h0000, 8'h00, 1'b0},
    {1'b1, 8'h22, 1'b1, 16'h0006, 8'h22, 1'b0},
    {1'b0, 8'h00, 1'b0, 16'h0000, 8'h00, 1'b0},
    // R2: unknown command discards the frame
    {1'b1, 8'h00, 1'b0, 16'h0000, 8'h00, 1'b0},
    {1'b1, 8'h7E, 1'b0, 16'h0000, 8'h00, 1'b0},
    {1'b1, 8'h12, 1'b0, 16'h0000, 8'h00, 1'b0},
    {1'b1, 8'h34, 1'b0, 16'h0000, 8'h00, 1'b0},
    {1'b1, 8'h01, 1'b0, 16'h0000, 8'h00, 1'b0},
    {1'b1, 8'h55, 1'b0, 16'h0000, 8'h00, 1'b0},
    // R6: wrap past 0xFFFF
    {1'b1, 8'h00, 1'b0, 16'h0000, 8'h00, 1'b0},
    {1'b1, 8'h21, 1'b0, 16'h0000, 8'h00, 1'b0},
    {1'b1, 8'hFF, 1'b0, 16'h0000, 8'h00, 1'b0},
    {1'b1, 8'hFF, 1'b0, 16'h0000, 8'h00, 1'b0},
    {1'b1, 8'h02, 1'b0, 16'h0000, 8'h00, 1'b0},
    {1'b1, 8'hA1, 1'b1, 16'hFFFF, 8'hA1, 1'b0},
    {1'b1, 8'hA2, 1'b1, 16'h0000, 8'hA2, 1'b0},
    {1'b0, 8'h00, 1'b0, 16'h0000, 8'h00, 1'b1},
    {1'b0, 8'h00, 1'b0, 16'h0000, 8'h00, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [7:0] b);
    rx_vld  = v;
    rx_byte = b;
    @(negedge clk);
    rx_vld  = 1'b0;
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      report();
    end
  end

  initial begin
    logic [34:0] e;
    rst_n    = 1'b0;
    rx_vld   = 1'b0;
    rx_byte  = 8'h00;
    ack_busy = 1'b0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 we",   bus_we,    0);
    check("R10 addr", bus_addr,  0);
    check("R10 data", bus_wdata, 0);
    check("R10 ack",  ack_vld,   0);
    check("R10 code", ack_byte,  0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      e = VEC[i];
      step(e[34], e[33:26]);
      check("R5 we", bus_we, e[25]);
      if (e[25]) begin
        check("R6 addr", bus_addr,  e[24:9]);
        check("R5 data", bus_wdata, e[8:1]);
      end
      check("R8 ack", ack_vld, e[0]);
      if (e[0]) check("R8 code", ack_byte, 8'hA5);
    end

    // R4: count byte 0 means 256 payload bytes
    step(1'b1, 8'h00); step(1'b1, 8'h20); step(1'b1, 8'h01);
    step(1'b1, 8'h00); step(1'b1, 8'h00);
    for (int k = 0; k < 256; k++) begin
      step(1'b1, 8'(k ^ 8'h5C));
      check("R4 we",   bus_we,    1);
      check("R4 addr", bus_addr,  32'h0100 + k);
      check("R4 data", bus_wdata, 8'(k ^ 8'h5C));
    end
    // R7: back to idle, a non-marker byte writes nothing
    step(1'b1, 8'h77);
    check("R7 we", bus_we, 0);
    step(1'b1, 8'h21);
    check("R7 we", bus_we, 0);

    // R8: busy transmitter holds the acknowledge
    ack_busy = 1'b1;
    step(1'b1, 8'h00); step(1'b1, 8'h21); step(1'b1, 8'h00);
    step(1'b1, 8'h10); step(1'b1, 8'h01);
    step(1'b1, 8'h99);
    check("R5 we", bus_we, 1);
    check("R6 addr", bus_addr, 16'h0010);
    for (int k = 0; k < 5; k++) begin
      step(1'b0, 8'h00);
      check("R8 held", ack_vld, 0);
    end
    ack_busy = 1'b0;
    step(1'b0, 8'h00);
    check("R8 release", ack_vld, 1);
    check("R8 code", ack_byte, 8'hA5);
    step(1'b0, 8'h00);
    check("R8 single", ack_vld, 0);

    // R10: reset mid-frame with an acknowledge pending
    ack_busy = 1'b1;
    step(1'b1, 8'h00); step(1'b1, 8'h21); step(1'b1, 8'h00);
    step(1'b1, 8'h30); step(1'b1, 8'h01); step(1'b1, 8'h66);
    step(1'b1, 8'h00); step(1'b1, 8'h21); step(1'b1, 8'h00);
    step(1'b1, 8'h40);
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 we",   bus_we,   0);
    check("R10 addr", bus_addr, 0);
    check("R10 code", ack_byte, 0);
    rst_n = 1'b1;
    ack_busy = 1'b0;
    step(1'b1, 8'h01);
    check("R10 ack", ack_vld, 0);
    step(1'b1, 8'h44);
    check("R10 we", bus_we, 0);
    check("R10 ack", ack_vld, 0);
    step(1'b0, 8'h00);
    check("R10 ack", ack_vld, 0);

    done = 1'b1;
    report();
  end

endmodule